// File: doc/BRIEF.md
# Per-Channel Input Event Interrupt Bank

This block keeps one control word for each channel of a bank of paired input/output lines. Each control word holds the channel's output value, its current input level, an interrupt enable and a 3-bit trigger code. New input levels arrive on a per-channel strobe. When a strobed level differs from the stored one, the channel's input tracker moves between its two states, `LINE_LOW` and `LINE_HIGH`. The move from `LINE_LOW` to `LINE_HIGH` is the `RISE` transition and the reverse is the `FALL` transition. A strobe that repeats the stored level takes no transition. Each transition is tested against the channel's trigger code. A match on an enabled channel sets a sticky status bit.

The status bits are packed into 32-bit words, and software reads them through a small synchronous register port together with the control words. Software acknowledges a channel by writing its control word with the self-clearing acknowledge bit set; there is no separate acknowledge register. A single interrupt line is high while any status bit is set. A write that flips a channel's output value produces a one-cycle notification pulse on that channel's notify output.

Top module: `gpio_irq_bank`

## Requirements
- R1: Trigger code (control bits 5:3) decoding is: 000 fires on a falling change, 001 on a rising change, 010 on a change to level 0, 011 on a change to level 1, and any code with bit 2 set fires on either change.
- R2: A channel with its enable (control bit 2) at 0 never sets its status bit, whatever its strobed input does.
- R3: A rising change is a strobed level of 1 when the stored level is 0, and a falling change is the reverse. Dual-edge codes accept both.
- R4: Triggers are evaluated only when a strobe carries a level different from the stored one. A strobe repeating the stored level sets nothing.
- R5: The bus address is IDX_W+1 bits wide. With the top bit 0, the low bits select status word k, which holds channel 32k+j at bit j. With the top bit 1, the low bits select a channel's control word. Read data appears on the cycle after the address is presented.
- R6: Writing a control word with the acknowledge bit (bit 6) at 1 clears that channel's status bit whether or not it was set. Bit 6 always reads back as 0.
- R7: The interrupt output is 1 exactly while at least one status bit is set, and it follows every status change within the same cycle as the status register.
- R8: A control write whose bit 0 differs from the stored output value pulses that channel's notify output for exactly one cycle after the write. A write that keeps the output value produces no pulse.
- R9: A read of a status word index at or beyond ceil(NUM_CH/32), or of a control word index at or beyond NUM_CH, returns 0. A write to a control word index at or beyond NUM_CH is ignored.
- R10: When an acknowledge and a new trigger for the same channel land in the same cycle, the status bit ends set.
- R11: Synchronous active-high reset clears every control field, every status bit, all notify pulses, the read data and the interrupt output.
- R12: Control word readback places the output value in bit 0, the stored input level in bit 1 (bus writes do not change it), the enable in bit 2 and the trigger code in bits 5:3. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | IDX_W+1 | Register address: top bit 0 selects a status word, top bit 1 selects a control word |
| bus_we | input | 1 | Write strobe for a control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_stb | input | NUM_CH | Per-channel input level update strobe |
| pin_lvl | input | NUM_CH | Per-channel input level, used when its strobe is high |
| irq | output | 1 | Combined interrupt, high while any status bit is set |
| out_note | output | NUM_CH | Per-channel one-cycle pulse after an output value change |

## Verification
The bench targets the acknowledge and trigger collision on one channel. A design that lets the acknowledge win there drops an event that arrived in the same cycle. It also sends strobes that repeat the stored level: a design that evaluates level modes on every strobe raises repeated interrupts from a line that has not moved. Status reads at channels 32 and above catch a wrong word and bit split. Out-of-range status and control addresses must read as zero. Writes that keep the output value must raise no notify pulse. The bench checks that the acknowledge bit never reads back, and that a disabled channel with a dual-edge code stays silent.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int F_OUT  = 0;
    localparam int F_IN   = 1;
    localparam int F_EN   = 2;
    localparam int F_TRIG = 3;
    localparam int TRIG_W = 3;
    localparam int F_ACK  = 6;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;

    function automatic logic trig_match(input logic [TRIG_W-1:0] code,
                                        input logic rise, input logic fall);
        logic r;
        if (code[2]) begin
            r = rise | fall;
        end else begin
            unique case (code[1:0])
                2'b00:   r = fall;
                2'b01:   r = rise;
                2'b10:   r = fall;
                2'b11:   r = rise;
                default: r = 1'b0;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic              wr_out,
    input  logic              wr_en,
    input  logic [TRIG_W-1:0] wr_trig,
    input  logic              wr_ack,
    input  logic              in_stb,
    input  logic              in_lvl,
    output logic [31:0]       ctrl_word,
    output logic              status,
    output logic              note
);
    line_state_e       st_q, st_d;
    logic              out_q, en_q, stat_q, note_q;
    logic [TRIG_W-1:0] trig_q;
    logic              rise, fall, hit;

    // Input tracker: state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= LINE_LOW;
        else     st_q <= st_d;
    end

    // Input tracker: transitions RISE and FALL
    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        unique case (st_q)
            LINE_LOW: begin
                if (in_stb && in_lvl) begin
                    st_d = LINE_HIGH;
                    rise = 1'b1;
                end
            end
            LINE_HIGH: begin
                if (in_stb && !in_lvl) begin
                    st_d = LINE_LOW;
                    fall = 1'b1;
                end
            end
            default: st_d = LINE_LOW;
        endcase
    end

    assign hit = en_q && trig_match(trig_q, rise, fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= 1'b0;
            en_q   <= 1'b0;
            trig_q <= '0;
        end else if (wr_sel) begin
            out_q  <= wr_out;
            en_q   <= wr_en;
            trig_q <= wr_trig;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  stat_q <= 1'b0;
        else if (hit)             stat_q <= 1'b1;
        else if (wr_sel && wr_ack) stat_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) note_q <= 1'b0;
        else     note_q <= wr_sel && (wr_out != out_q);
    end

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[F_OUT]                = out_q;
        ctrl_word[F_IN]                 = (st_q == LINE_HIGH);
        ctrl_word[F_EN]                 = en_q;
        ctrl_word[F_TRIG +: TRIG_W]     = trig_q;
    end

    assign status = stat_q;
    assign note   = note_q;

    // R2: a disabled, idle channel stays clear
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !stat_q) |=> !stat_q);
    // R4: without a strobe no status bit can appear
    p_no_stb_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!in_stb && !stat_q) |=> !stat_q);
    // R6: acknowledge without competing strobe leaves the bit clear
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wr_ack && !in_stb) |=> !stat_q);
    // R8: a notify pulse follows a write
    p_note_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        note_q |-> $past(wr_sel));
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux #(
    parameter int NUM_CH = 64,
    parameter int IDX_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W:0]         addr,
    input  logic [NUM_CH-1:0]      stat_vec,
    input  logic [NUM_CH-1:0][31:0] ctrl_words,
    output logic [31:0]            rdata
);
    localparam int STAT_WORDS = (NUM_CH + 31) / 32;

    logic [STAT_WORDS*32-1:0] stat_pad;
    logic [IDX_W-1:0]         idx;
    logic [31:0]              rd_d;

    assign idx = addr[IDX_W-1:0];

    always_comb begin
        stat_pad               = '0;
        stat_pad[NUM_CH-1:0]   = stat_vec;
    end

    always_comb begin
        rd_d = '0;
        if (addr[IDX_W]) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (idx == IDX_W'(i)) rd_d = ctrl_words[i];
            end
        end else begin
            for (int w = 0; w < STAT_WORDS; w++) begin
                if (idx == IDX_W'(w)) rd_d = stat_pad[w*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_d;
    end

    // R9: out-of-range status word index reads zero
    p_oob_status_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!addr[IDX_W] && (int'(idx) >= STAT_WORDS)) |=> (rdata == 32'd0));
    // R9: out-of-range control index reads zero
    p_oob_ctrl_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (addr[IDX_W] && (int'(idx) >= NUM_CH)) |=> (rdata == 32'd0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W:0]    bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] pin_stb,
    input  logic [NUM_CH-1:0] pin_lvl,
    output logic              irq,
    output logic [NUM_CH-1:0] out_note
);
    logic [NUM_CH-1:0]       stat_vec;
    logic [NUM_CH-1:0][31:0] ctrl_words;
    logic                    wdata_unused;

    assign wdata_unused = ^bus_wdata[31:F_ACK+1];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic sel;
        assign sel = bus_we && bus_addr[IDX_W] &&
                     (bus_addr[IDX_W-1:0] == IDX_W'(g));
        gpio_irq_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_sel    (sel),
            .wr_out    (bus_wdata[F_OUT]),
            .wr_en     (bus_wdata[F_EN]),
            .wr_trig   (bus_wdata[F_TRIG +: TRIG_W]),
            .wr_ack    (bus_wdata[F_ACK]),
            .in_stb    (pin_stb[g]),
            .in_lvl    (pin_lvl[g]),
            .ctrl_word (ctrl_words[g]),
            .status    (stat_vec[g]),
            .note      (out_note[g])
        );
    end

    gpio_irq_rdmux #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .stat_vec   (stat_vec),
        .ctrl_words (ctrl_words),
        .rdata      (bus_rdata)
    );

    assign irq = |stat_vec;

    // R7: a new interrupt needs an input strobe in the prior cycle
    p_irq_rise_needs_stb_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|pin_stb));
    // R7: interrupt can only drop after a control write
    p_irq_fall_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_we));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
    localparam int NCH = 64;
    localparam int IW  = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic [IW:0]     d_addr;
    logic            d_we;
    logic [31:0]     d_wdata;
    logic [NCH-1:0]  d_stb, d_lvl;
    logic [31:0]     rdata;
    logic            irq;
    logic [NCH-1:0]  note;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit       m_out [NCH];
    bit       m_in  [NCH];
    bit       m_en  [NCH];
    bit [2:0] m_trig[NCH];
    bit       m_stat[NCH];
    logic [NCH-1:0] exp_note;
    logic [31:0]    exp_rd;

    always #2 clk = ~clk;

    gpio_irq_bank #(.NUM_CH(NCH), .IDX_W(IW)) u_gpio_irq_bank (
        .clk(clk), .rst(rst), .bus_addr(d_addr), .bus_we(d_we),
        .bus_wdata(d_wdata), .bus_rdata(rdata), .pin_stb(d_stb),
        .pin_lvl(d_lvl), .irq(irq), .out_note(note));

    function automatic bit fires(bit [2:0] c, bit prev, bit nw);
        if (prev == nw) return 0;
        if (c[2]) return 1;
        case (c[1:0])
            2'd0: return prev & ~nw;
            2'd1: return ~prev & nw;
            2'd2: return ~nw;
            default: return nw;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [IW:0] a);
        logic [31:0] v = '0;
        int k = int'(a[IW-1:0]);
        if (a[IW]) begin
            if (k < NCH) v = {26'd0, m_trig[k], m_en[k], m_in[k], m_out[k]};
        end else begin
            for (int j = 0; j < 32; j++)
                if (k*32 + j < NCH) v[j] = m_stat[k*32 + j];
        end
        return v;
    endfunction

    function automatic bit any_stat();
        for (int i = 0; i < NCH; i++) if (m_stat[i]) return 1;
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_drv();
        d_we = 0; d_wdata = '0; d_stb = '0;
    endtask

    task automatic cycle();
        exp_rd = rst ? 32'd0 : model_read(d_addr);
        for (int c = 0; c < NCH; c++) begin
            bit wr, hit;
            wr  = d_we && d_addr[IW] && (int'(d_addr[IW-1:0]) == c);
            hit = m_en[c] && d_stb[c] && fires(m_trig[c], m_in[c], d_lvl[c]);
            exp_note[c] = !rst && wr && (d_wdata[0] != m_out[c]);
            if (rst) begin
                m_out[c] = 0; m_in[c] = 0; m_en[c] = 0; m_trig[c] = 0; m_stat[c] = 0;
            end else begin
                if (d_stb[c]) m_in[c] = d_lvl[c];
                if (hit) m_stat[c] = 1;
                else if (wr && d_wdata[6]) m_stat[c] = 0;
                if (wr) begin
                    m_out[c] = d_wdata[0]; m_en[c] = d_wdata[2]; m_trig[c] = d_wdata[5:3];
                end
            end
        end
        @(posedge clk); #1;
        chk("R5 read data", rdata, exp_rd);
        chk("R8 notify", note, exp_note);
        chk("R7 irq", {31'd0, irq}, {31'd0, any_stat()});
        idle_drv();
    endtask

    task automatic wr_ctrl(int ch, bit en, bit [2:0] trig, bit out, bit ack);
        d_we = 1; d_addr = {1'b1, IW'(ch)};
        d_wdata = {25'd0, ack, trig, en, 1'b0, out};
        cycle();
    endtask

    task automatic pin(int ch, bit lvl);
        d_stb[ch] = 1; d_lvl[ch] = lvl;
        cycle();
    endtask

    task automatic rd(logic [IW:0] a);
        d_addr = a;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; d_addr = '0; d_lvl = '0; idle_drv();
        repeat (3) cycle();
        rst = 0;
        rd('0); chk("R11 status after reset", rdata, 32'd0);
        chk("R11 irq after reset", {31'd0, irq}, 32'd0);
        rd({1'b1, IW'(5)}); chk("R11 control after reset", rdata, 32'd0);

        // ch5 falling mode
        wr_ctrl(5, 1, 3'b000, 0, 0);
        pin(5, 1); rd('0); chk("R1 falling mode ignores rise", rdata, 32'd0);
        pin(5, 0); rd('0); chk("R1 falling mode fires", rdata, 32'h20);
        chk("R7 irq set", {31'd0, irq}, 32'd1);
        wr_ctrl(5, 1, 3'b000, 0, 1); rd('0); chk("R6 ack clears", rdata, 32'd0);
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);
        rd({1'b1, IW'(5)}); chk("R6 ack bit not stored", rdata, 32'h04);
        wr_ctrl(5, 1, 3'b000, 0, 1); rd('0); chk("R6 ack when idle", rdata, 32'd0);

        // ch40 rising: word 1, bit 8
        wr_ctrl(40, 1, 3'b001, 0, 0);
        pin(40, 1); rd(9'd1); chk("R5 word1 bit8", rdata, 32'h100);
        rd({1'b1, IW'(40)}); chk("R12 control layout", rdata, 32'h0E);
        wr_ctrl(40, 1, 3'b001, 0, 1);

        // level modes
        wr_ctrl(7, 1, 3'b010, 0, 0); wr_ctrl(8, 1, 3'b011, 0, 0);
        pin(7, 1); pin(8, 1); rd('0); chk("R1 level high fires, low not", rdata, 32'h100);
        pin(7, 0); rd('0); chk("R1 level low fires", rdata, 32'h180);
        wr_ctrl(7, 1, 3'b010, 0, 1); wr_ctrl(8, 1, 3'b011, 0, 1);

        // dual edge code 111
        wr_ctrl(9, 1, 3'b111, 0, 0);
        pin(9, 1); rd('0); chk("R3 dual edge rise", rdata, 32'h200);
        wr_ctrl(9, 1, 3'b111, 0, 1);
        pin(9, 0); rd('0); chk("R3 dual edge fall", rdata, 32'h200);
        wr_ctrl(9, 1, 3'b111, 0, 1);

        // disabled
        wr_ctrl(10, 0, 3'b100, 0, 0);
        pin(10, 1); pin(10, 0); pin(10, 1); rd('0); chk("R2 disabled silent", rdata, 32'd0);

        // repeated level
        wr_ctrl(11, 1, 3'b011, 0, 0);
        pin(11, 1); wr_ctrl(11, 1, 3'b011, 0, 1);
        pin(11, 1); pin(11, 1); rd('0); chk("R4 same level no event", rdata, 32'd0);

        // ack and trigger together
        wr_ctrl(12, 1, 3'b001, 0, 0);
        pin(12, 1); pin(12, 0);
        d_stb[12] = 1; d_lvl[12] = 1;
        wr_ctrl(12, 1, 3'b001, 0, 1);
        rd('0); chk("R10 trigger beats ack", rdata, 32'h1000);
        wr_ctrl(12, 1, 3'b001, 0, 1);

        // notify pulse
        d_we = 1; d_addr = {1'b1, IW'(3)}; d_wdata = 32'h1;
        cycle(); chk("R8 pulse on change", {31'd0, note[3]}, 32'd1);
        cycle(); chk("R8 pulse one cycle", {31'd0, note[3]}, 32'd0);
        wr_ctrl(3, 0, 3'b000, 1, 0); chk("R8 no pulse same value", {31'd0, note[3]}, 32'd0);

        // out of range
        rd(9'd5); chk("R9 status index beyond", rdata, 32'd0);
        wr_ctrl(100, 1, 3'b111, 1, 0);
        rd({1'b1, IW'(100)}); chk("R9 control index beyond", rdata, 32'd0);

        // random phase
        void'($urandom(32'h5eed1234));
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 100;
            d_stb = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            d_lvl = {$urandom, $urandom};
            if (r < 35) begin
                d_we = 1;
                d_addr = {1'b1, 1'b0, 7'($urandom)};
                d_wdata = $urandom;
            end else if (r < 70) begin
                d_addr = {1'b0, 8'($urandom % 10)};
            end else begin
                d_addr = {1'b1, 1'b0, 7'($urandom)};
            end
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule